// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a small accumulator machine. On each cycle where an operation is presented, it takes the current accumulator value, one register operand and a 4-bit operation select. It then registers three things: the next accumulator value, the carry/borrow flag, and the extension byte. Decode of instruction bytes, operand fetch, the register file and branching belong to the surrounding core. That core feeds the registered result back as the next accumulator input and steers conditional branches from the flag.

The operations are of four kinds: arithmetic (add, subtract, increment, decrement), compare, multiply, and bitwise or shift operations. Each kind has its own rule for the side state:

- Arithmetic operations rewrite the flag.
- Compare rewrites only the flag and passes the accumulator through.
- Multiply splits the double-width product between the accumulator and the extension byte, and leaves the flag untouched.
- Logic and shift operations touch neither the flag nor the extension byte.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_next_q`, `cy_q` and `ext_q` all become 0.
- R2: At a clock edge with `op_valid` low, all three outputs keep their values whatever the other inputs carry.
- R3: Select 1 (add) gives `acc_next_q` = (acc + opnd) mod 256 and `cy_q` = carry out of bit 7.
- R4: Select 2 (subtract) gives `acc_next_q` = (acc - opnd) mod 256 and `cy_q` = 1 exactly when acc < opnd unsigned.
- R5: Select 4 (compare) gives `acc_next_q` = acc unchanged and `cy_q` = 1 exactly when acc < opnd unsigned, else 0.
- R6: Select 3 (multiply) puts the low byte of acc × opnd in `acc_next_q` and the high byte in `ext_q`, and keeps `cy_q`.
- R7: Select 5 (increment) and select 6 (decrement) wrap modulo 256. The flag becomes 1 when increment starts at 0xFF or decrement starts at 0x00, and 0 otherwise.
- R8: Select 7 (AND) and select 8 (XOR) give the bitwise result of acc and opnd, and keep `cy_q`.
- R9: Select 9 (shift left) and select 10 (shift right) move acc by one bit, fill the vacated bit with 0, and keep `cy_q`.
- R10: Select 11 (rotate right) moves bit 0 into bit 7, and select 12 (rotate left) moves bit 7 into bit 0. Both keep `cy_q`.
- R11: Select 13 (arithmetic right shift) shifts acc right by one, copies bit 7 into itself, and keeps `cy_q`.
- R12: `ext_q` changes only on a valid multiply.
- R13: Selects 0, 14 and 15 pass acc to `acc_next_q` and keep `cy_q` and `ext_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the selected operation at this edge |
| op_sel | input | 4 | Operation select code |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Register operand |
| acc_next_q | output | 8 | Registered next accumulator value |
| cy_q | output | 1 | Registered carry/borrow flag |
| ext_q | output | 8 | Registered extension byte (high half of product) |

## Verification
The bench sweeps every accumulator value against sixteen operands spread across the byte, and computes the expected sum, difference, product and shift by plain integer arithmetic. The checks target several likely mistakes:
- Wrap edges: increment from 0xFF and decrement from 0x00 catch a flag that ignores the wrap or a result that saturates.
- Full-range multiply: 0xFF × 0xFF catches a truncated or mis-split product.
- Flag keeping: before every operation that must keep the flag, a compare drives the flag to 0 or to 1. A design that clears or rewrites the flag on logic, shift or multiply steps therefore shows the wrong value.
- Shift fill: a shift that fills with the sign bit, or a rotate that drops the wrapped bit, differs from the arithmetic model on half of all inputs.
- Idle and reserved cycles: a design that acts on idle cycles or reserved selects moves the outputs where they must hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_MUL = 4'd3,
    OP_CMP = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_AND = 4'd7,
    OP_XOR = 4'd8,
    OP_LSL = 4'd9,
    OP_LSR = 4'd10,
    OP_ROR = 4'd11,
    OP_ROL = 4'd12,
    OP_ASR = 4'd13
  } op_e;

  // Operations that must leave the carry/borrow flag alone.
  function automatic logic keeps_flag(input logic [OP_W-1:0] code);
    case (code)
      OP_MUL, OP_AND, OP_XOR, OP_LSL, OP_LSR, OP_ROR, OP_ROL, OP_ASR: keeps_flag = 1'b1;
      default: keeps_flag = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         cy_we,
  output logic         hit
);
  localparam int XW = W + 1;

  logic [XW-1:0] sum_x;
  logic [XW-1:0] diff_x;
  logic [XW-1:0] inc_x;
  logic [XW-1:0] dec_x;

  // One extra bit on each path holds carry out or borrow.
  always_comb begin
    sum_x  = {1'b0, a} + {1'b0, b};
    diff_x = {1'b0, a} - {1'b0, b};
    inc_x  = {1'b0, a} + XW'(1);
    dec_x  = {1'b0, a} - XW'(1);
  end

  always_comb begin
    res   = a;
    cy    = 1'b0;
    cy_we = 1'b0;
    hit   = 1'b0;
    case (op)
      OP_ADD: begin res = sum_x[W-1:0];  cy = sum_x[W];  cy_we = 1'b1; hit = 1'b1; end
      OP_SUB: begin res = diff_x[W-1:0]; cy = diff_x[W]; cy_we = 1'b1; hit = 1'b1; end
      OP_CMP: begin res = a;             cy = diff_x[W]; cy_we = 1'b1; hit = 1'b1; end
      OP_INC: begin res = inc_x[W-1:0];  cy = inc_x[W];  cy_we = 1'b1; hit = 1'b1; end
      OP_DEC: begin res = dec_x[W-1:0];  cy = dec_x[W];  cy_we = 1'b1; hit = 1'b1; end
      default: ;
    endcase
  end

  // R4: a borrow on subtract means the operand exceeded the accumulator.
  always_comb begin
    if (op == OP_SUB) begin
      p_borrow_order_r4: assert (cy == (a < b));
    end
  end
endmodule

// File: rtl/acc_mul_unit.sv
module acc_mul_unit #(
  parameter int W         = 8,
  parameter bit SHIFT_ADD = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;

  generate
    if (SHIFT_ADD) begin : g_shift_add
      // Explicit partial-product sum for fabrics without DSP slices.
      always_comb begin
        prod = '0;
        for (int i = 0; i < W; i++) begin
          if (b[i]) prod = prod + ({{W{1'b0}}, a} << i);
        end
      end
    end else begin : g_direct
      assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    end
  endgenerate

  assign lo = prod[W-1:0];
  assign hi = prod[PW-1:W];
endmodule

// File: rtl/acc_bitwise_unit.sv
module acc_bitwise_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         hit
);
  always_comb begin
    res = a;
    hit = 1'b1;
    case (op)
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_LSL: res = {a[W-2:0], 1'b0};
      OP_LSR: res = {1'b0, a[W-1:1]};
      OP_ROR: res = {a[0], a[W-1:1]};
      OP_ROL: res = {a[W-2:0], a[W-1]};
      OP_ASR: res = {a[W-1], a[W-1:1]};
      default: begin res = a; hit = 1'b0; end
    endcase
  end

  // R11: the sign bit survives the arithmetic shift.
  always_comb begin
    if (op == OP_ASR) begin
      p_sign_kept_r11: assert (res[W-1] == a[W-1]);
    end
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_alu_pkg::*;
#(
  parameter int W         = 8,
  parameter bit SHIFT_ADD = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  output logic [W-1:0] acc_next_q,
  output logic         cy_q,
  output logic [W-1:0] ext_q
);
  op_e op;
  assign op = op_e'(op_sel);

  logic [W-1:0] ar_res;
  logic         ar_cy;
  logic         ar_cy_we;
  logic         ar_hit;
  logic [W-1:0] mul_lo;
  logic [W-1:0] mul_hi;
  logic [W-1:0] bw_res;
  logic         bw_hit;

  acc_arith_unit #(.W(W)) u_arith (
    .op(op), .a(acc_in), .b(opnd_in),
    .res(ar_res), .cy(ar_cy), .cy_we(ar_cy_we), .hit(ar_hit)
  );

  acc_mul_unit #(.W(W), .SHIFT_ADD(SHIFT_ADD)) u_mul (
    .a(acc_in), .b(opnd_in), .lo(mul_lo), .hi(mul_hi)
  );

  acc_bitwise_unit #(.W(W)) u_bitwise (
    .op(op), .a(acc_in), .b(opnd_in), .res(bw_res), .hit(bw_hit)
  );

  logic [W-1:0] nxt_res;
  logic         nxt_cy;
  logic [W-1:0] nxt_ext;

  always_comb begin
    nxt_res = acc_in;
    nxt_cy  = cy_q;
    nxt_ext = ext_q;
    if (ar_hit) begin
      nxt_res = ar_res;
      if (ar_cy_we) nxt_cy = ar_cy;
    end else if (op == OP_MUL) begin
      nxt_res = mul_lo;
      nxt_ext = mul_hi;
    end else if (bw_hit) begin
      nxt_res = bw_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_next_q <= '0;
      cy_q       <= 1'b0;
      ext_q      <= '0;
    end else if (op_valid) begin
      acc_next_q <= nxt_res;
      cy_q       <= nxt_cy;
      ext_q      <= nxt_ext;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid)) |->
      ($stable(acc_next_q) && $stable(cy_q) && $stable(ext_q)));

  p_cmp_passes_acc_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_sel) == 4'(OP_CMP)) |->
      (acc_next_q == $past(acc_in)));

  p_flag_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && keeps_flag($past(op_sel))) |->
      (cy_q == $past(cy_q)));

  p_ext_only_mul_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_sel) != 4'(OP_MUL)) |->
      (ext_q == $past(ext_q)));

  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_sel) == 4'(OP_INC) && $past(acc_in) == {W{1'b1}}) |->
      (acc_next_q == '0 && cy_q));

  p_dec_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_sel) == 4'(OP_DEC) && $past(acc_in) == '0) |->
      (acc_next_q == {W{1'b1}} && cy_q));
endmodule

// File: tb/acc_exec_unit_bench.sv
module acc_exec_unit_bench;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opnd_in = '0;
  logic [7:0] acc_next_q;
  logic       cy_q;
  logic [7:0] ext_q;

  int  checks = 0;
  int  failures = 0;
  int  m_res = 0;
  int  m_cy = 0;
  int  m_ext = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_exec_unit u_acc_exec_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in),
    .acc_next_q(acc_next_q), .cy_q(cy_q), .ext_q(ext_q)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "acc", int'(acc_next_q), m_res);
    check(req, "flag", int'(cy_q), m_cy);
    check("R12", "ext", int'(ext_q), m_ext);
  endtask

  // Called at a falling edge; drives one op and samples at the next falling edge.
  task automatic run_op(input int op, input int a, input int b, input string req);
    int r;
    int c;
    int e;
    r = a;
    c = m_cy;
    e = m_ext;
    case (op)
      1:  begin r = (a + b) % 256;       c = (a + b > 255) ? 1 : 0; end
      2:  begin r = (a - b + 256) % 256; c = (a < b) ? 1 : 0; end
      3:  begin r = (a * b) % 256;       e = (a * b) / 256; end
      4:  begin r = a;                   c = (a < b) ? 1 : 0; end
      5:  begin r = (a + 1) % 256;       c = (a == 255) ? 1 : 0; end
      6:  begin r = (a + 255) % 256;     c = (a == 0) ? 1 : 0; end
      7:  r = a & b;
      8:  r = a ^ b;
      9:  r = (a * 2) % 256;
      10: r = a / 2;
      11: r = (a / 2) + (a % 2) * 128;
      12: r = (a * 2) % 256 + a / 128;
      13: r = (a / 2) + (a & 128);
      default: r = a;
    endcase
    op_valid = 1'b1;
    op_sel   = op[3:0];
    acc_in   = a[7:0];
    opnd_in  = b[7:0];
    @(negedge clk);
    op_valid = 1'b0;
    m_res = r;
    m_cy  = c;
    m_ext = e;
    check_all(req);
  endtask

  // Force the flag to a known value with a compare (R5).
  task automatic prime(input int v);
    if (v != 0) run_op(4, 0, 1, "R5");
    else        run_op(4, 1, 0, "R5");
  endtask

  task automatic idle(input int a);
    op_valid = 1'b0;
    op_sel   = 4'd1;
    acc_in   = a[7:0];
    opnd_in  = 8'hC3;
    @(negedge clk);
    check_all("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    idle(8'h5A);

    run_op(1, 255, 1, "R3");
    run_op(2, 0, 1, "R4");
    run_op(3, 255, 255, "R6");
    idle(8'h11);
    run_op(5, 255, 0, "R7");
    run_op(6, 0, 0, "R7");
    run_op(5, 17, 0, "R7");
    run_op(3, 16, 16, "R6");

    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 16; j++) begin
        run_op(1, a, j * 17, "R3");
        run_op(2, a, j * 17, "R4");
        run_op(4, a, j * 17, "R5");
        prime((a + j) % 2);
        run_op(3, a, j * 17, "R6");
        prime((a + j + 1) % 2);
        run_op(7, a, j * 17, "R8");
        prime((a + j) % 2);
        run_op(8, a, j * 17, "R8");
      end
    end

    for (int a = 0; a < 256; a++) begin
      prime(a % 2);      run_op(5, a, 0, "R7");
      prime(a % 2);      run_op(6, a, 0, "R7");
      prime(a % 2);      run_op(9, a, 0, "R9");
      prime((a + 1) % 2); run_op(10, a, 0, "R9");
      prime(a % 2);      run_op(11, a, 0, "R10");
      prime((a + 1) % 2); run_op(12, a, 0, "R10");
      prime(a % 2);      run_op(13, a, 0, "R11");
      prime((a + 1) % 2); run_op(14, a, 255 - a, "R13");
      prime(a % 2);      run_op(15, a, a, "R13");
      prime((a + 1) % 2); run_op(0, a, 1, "R13");
      idle(255 - a);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule